// File: doc/BRIEF.md
# Truncated Merged Multiply-Accumulate

This block forms the dot product of a set of two's-complement sample words with a coefficient set fixed at build time. The result is returned as one fixed-width word. The taps are not multiplied one by one and then added. Every partial-product bit of every tap, and one constant row, goes into a single bit matrix. A chain of 3:2 compressors reduces that matrix to a sum row and a carry row, and one carry-propagate adder finishes the sum. The result is registered in a single pipeline stage.

To save area, the lowest columns of the matrix are never built. The constant row carries the sign corrections and a rounding bias that offsets the deleted bits. Only the top bits of the accumulator are kept. The number of deleted columns is a parameter. The bias is chosen so that the output always stays within one unit in the last place of the exact sum. A filter datapath presents all tap samples in parallel with a valid strobe and receives the filtered word one cycle later.

Top module: `merged_trunc_mac`

## Requirements
- R1: With L = ACC_W - OUT_W, where ACC_W = 2*16 + clog2(TAPS) and L defaults to 10, every result satisfies |signed(outSum)*2^L - S| <= 2^L. Here S is the exact sum over taps of signed sample times signed coefficient.
- R2: Matrix columns below DROP_COLS (default 5) are deleted, and a bias C = floor((D + 2^L)/2) is added, with D = TAPS*((DROP_COLS-1)*2^DROP_COLS + 1); the default C is 770. When the low DROP_COLS bits of every sample are zero, outSum equals floor((S + C) / 2^L) exactly.
- R3: A result computed from all-zero samples is exactly zero.
- R4: The most negative sample (-32768) against the most negative coefficient gives the correct positive product, with no overflow of the sum.
- R5: A sample set captured while inValid is high appears on outSum with outValid high exactly one clock later.
- R6: In a cycle after inValid was low, outValid is low and outSum holds its previous value, whatever sampleVec carries.
- R7: While rstN is low, outValid and outSum are zero.
- R8: Sample sets presented on consecutive cycles each produce their own result, in order, with none lost or repeated.
- R9: Tap t takes its sample from sampleVec[16t+15:16t] and pairs it with coefficient t. The default coefficients for taps 0 to 3 are -100, 4660, 32767 and -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Sample set on sampleVec is valid this cycle |
| sampleVec | input | TAPS*16 | Packed signed samples, tap 0 in the low word |
| outValid | output | 1 | outSum carries a new result |
| outSum | output | OUT_W | Signed truncated dot product, weight 2^L per LSB |

## Verification
In one matrix, two things can act at the same time: the sign-correction bits of a tap, and the deleted low columns together with the rounding bias. The bench provokes this with sets of most-negative and all-ones samples, where the inverted sign bits and the deleted columns are both fully populated. Each such result is judged against the exact integer sum under the one-ULP bound, and against the exact rounding formula whenever the deleted columns are empty. A new capture can also coincide with the presentation of the previous result. This is provoked by long runs of back-to-back random sample sets, which a queue of expected values tracks in order.

// File: rtl/tmac_pkg.sv
package tmac_pkg;

  typedef struct packed {
    logic capture;
  } tmacStrobe_t;

  // Constant matrix row: sign-correction constants of every tap plus the
  // bias that offsets the deleted low columns and rounds at the output LSB.
  function automatic logic [63:0] biasRow(int taps, int sw, int cw, int dropCols, int lsb);
    longint delMax;
    longint roundC;
    longint corr;
    delMax = longint'(taps) * ((longint'(dropCols) - 1) * (64'sd1 <<< dropCols) + 1);
    roundC = (delMax + (64'sd1 <<< lsb)) / 2;
    corr = -((64'sd1 <<< (sw + cw - 2)) - (64'sd1 <<< (cw - 1)))
           - ((64'sd1 <<< (sw + cw - 2)) - (64'sd1 <<< (sw - 1)));
    return 64'(longint'(taps) * corr + roundC);
  endfunction

endpackage

// File: rtl/tmac_csa.sv
module tmac_csa #(
  parameter int W = 34
) (
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  logic [W-1:0] cIn,
  output logic [W-1:0] sumOut,
  output logic [W-1:0] carOut
);
  assign sumOut = aIn ^ bIn ^ cIn;
  assign carOut = {(aIn[W-2:0] & bIn[W-2:0]) | (aIn[W-2:0] & cIn[W-2:0]) |
                   (bIn[W-2:0] & cIn[W-2:0]), 1'b0};
endmodule

// File: rtl/tmac_ctrl.sv
module tmac_ctrl
  import tmac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output tmacStrobe_t strobe,
  output logic        outValid
);
  assign strobe.capture = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/tmac_datapath.sv
module tmac_datapath
  import tmac_pkg::*;
#(
  parameter int TAPS = 4,
  parameter int SW = 16,
  parameter int CW = 16,
  parameter int ACC_W = 34,
  parameter int OUT_W = 24,
  parameter int DROP_COLS = 5,
  parameter logic [63:0] BIAS = '0,
  parameter logic [TAPS*CW-1:0] COEFS = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  tmacStrobe_t         strobe,
  input  logic [TAPS*SW-1:0]  sampleVec,
  output logic [OUT_W-1:0]    outSum
);
  localparam int ROWS = TAPS * CW + 1;
  localparam int STAGES = ROWS - 2;
  localparam int OUT_LSB = ACC_W - OUT_W;

  logic [ACC_W-1:0] ppRow [ROWS];

  // Baugh-Wooley matrix: cross-sign bits inverted, low columns removed.
  always_comb begin
    for (int r = 0; r < ROWS; r++) ppRow[r] = '0;
    for (int t = 0; t < TAPS; t++) begin
      for (int j = 0; j < CW; j++) begin
        for (int i = 0; i < SW; i++) begin
          logic ppBit;
          ppBit = sampleVec[t*SW + i] & COEFS[t*CW + j];
          if ((i == SW - 1) != (j == CW - 1)) ppBit = ~ppBit;
          if (i + j < DROP_COLS) ppBit = 1'b0;
          ppRow[t*CW + j][i + j] = ppBit;
        end
      end
    end
    ppRow[ROWS-1] = BIAS[ACC_W-1:0];
  end

  logic [ACC_W-1:0] sumV [STAGES];
  logic [ACC_W-1:0] carV [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_csa
    if (k == 0) begin : g_first
      tmac_csa #(.W(ACC_W)) u_csa (
        .aIn(ppRow[0]), .bIn(ppRow[1]), .cIn(ppRow[2]),
        .sumOut(sumV[0]), .carOut(carV[0])
      );
    end else begin : g_next
      tmac_csa #(.W(ACC_W)) u_csa (
        .aIn(sumV[k-1]), .bIn(carV[k-1]), .cIn(ppRow[k+2]),
        .sumOut(sumV[k]), .carOut(carV[k])
      );
    end
  end

  logic [ACC_W-1:0] accNext;
  assign accNext = sumV[STAGES-1] + carV[STAGES-1];

  logic unusedLow;
  assign unusedLow = ^accNext[OUT_LSB-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               outSum <= '0;
    else if (strobe.capture) outSum <= accNext[ACC_W-1:OUT_LSB];
  end
endmodule

// File: rtl/merged_trunc_mac.sv
module merged_trunc_mac
  import tmac_pkg::*;
#(
  parameter int TAPS = 4,
  parameter int OUT_W = 24,
  parameter int DROP_COLS = 5,
  parameter logic [TAPS*16-1:0] COEFS = {16'h8000, 16'h7FFF, 16'h1234, 16'hFF9C}
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [TAPS*16-1:0]   sampleVec,
  output logic                 outValid,
  output logic [OUT_W-1:0]     outSum
);
  localparam int SW = 16;
  localparam int CW = 16;
  localparam int ACC_W = SW + CW + $clog2(TAPS);
  localparam int OUT_LSB = ACC_W - OUT_W;
  localparam logic [63:0] BIAS = biasRow(TAPS, SW, CW, DROP_COLS, OUT_LSB);

  tmacStrobe_t strobe;

  tmac_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobe(strobe), .outValid(outValid)
  );

  tmac_datapath #(
    .TAPS(TAPS), .SW(SW), .CW(CW), .ACC_W(ACC_W), .OUT_W(OUT_W),
    .DROP_COLS(DROP_COLS), .BIAS(BIAS), .COEFS(COEFS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .sampleVec(sampleVec), .outSum(outSum)
  );
endmodule

// File: rtl/tmac_checker.sv
module tmac_checker #(
  parameter int TAPS = 4,
  parameter int OUT_W = 24,
  parameter logic [TAPS*16-1:0] COEFS = '0
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [TAPS*16-1:0] sampleVec,
  input logic               outValid,
  input logic [OUT_W-1:0]   outSum
);
  localparam int OUT_LSB = 32 + $clog2(TAPS) - OUT_W;
  localparam longint ULP = 64'sd1 <<< OUT_LSB;

  longint refSum;
  longint scaledOut;

  always_comb begin
    refSum = 0;
    for (int t = 0; t < TAPS; t++)
      refSum += longint'($signed(sampleVec[t*16 +: 16])) * longint'($signed(COEFS[t*16 +: 16]));
  end

  assign scaledOut = longint'($signed(outSum)) <<< OUT_LSB;

  // R1: one-ULP bound against the exact sum of the captured set
  a_r1_ulp_bound: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ((scaledOut - $past(refSum) <= ULP) && (scaledOut - $past(refSum) >= -ULP)));

  // R3
  a_r3_zero_in_zero_out: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && sampleVec == '0) |=> (outSum == '0));

  // R5
  a_r5_one_cycle_latency: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R6
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(outSum)));

  // R7
  always @(negedge clk) begin
    if (!rstN) a_r7_reset_clear: assert (!outValid && outSum == '0);
  end
endmodule

bind merged_trunc_mac tmac_checker #(.TAPS(TAPS), .OUT_W(OUT_W), .COEFS(COEFS)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .sampleVec(sampleVec),
  .outValid(outValid), .outSum(outSum)
);

// File: tb/sim_merged_trunc_mac.sv
module sim_merged_trunc_mac;
  localparam int TAPS = 4;
  localparam int OUT_W = 24;
  localparam int LSB = 10;
  localparam int DROP = 5;
  localparam longint ROUNDC = 770;
  localparam longint ULP = 1024;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [TAPS*16-1:0] sampleVec = '0;
  logic outValid;
  logic [OUT_W-1:0] outSum;

  int checks = 0;
  int failures = 0;
  int pushed = 0;
  int popped = 0;
  bit done = 0;
  longint coefTab [TAPS] = '{-100, 4660, 32767, -32768};

  typedef struct {
    longint exact;
    bit     lowClear;
  } item_t;
  item_t sb [$];

  merged_trunc_mac u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sampleVec(sampleVec),
    .outValid(outValid), .outSum(outSum)
  );

  always #10 clk = ~clk;

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exactOf(logic [TAPS*16-1:0] v);
    longint s = 0;
    for (int t = 0; t < TAPS; t++) s += longint'($signed(v[t*16 +: 16])) * coefTab[t];
    return s;
  endfunction

  function automatic bit lowClearOf(logic [TAPS*16-1:0] v);
    bit c = 1;
    for (int t = 0; t < TAPS; t++) if (v[t*16 +: DROP] != '0) c = 0;
    return c;
  endfunction

  function automatic longint outVal();
    return longint'($signed(outSum));
  endfunction

  // driver: one set per call, on the falling edge
  task automatic send(logic [TAPS*16-1:0] v);
    item_t it;
    @(negedge clk);
    inValid = 1'b1;
    sampleVec = v;
    it.exact = exactOf(v);
    it.lowClear = lowClearOf(v);
    sb.push_back(it);
    pushed++;
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (sb.size() == 0) begin
        check(0, "R8 unexpected result", outVal(), 0);
      end else begin
        item_t it;
        longint err;
        it = sb.pop_front();
        popped++;
        err = (outVal() * ULP) - it.exact;
        check(err <= ULP && err >= -ULP, "R1 ulp bound", outVal() * ULP, it.exact);
        if (it.lowClear)
          check(outVal() == ((it.exact + ROUNDC) >>> LSB), "R2 exact rounding",
                outVal(), (it.exact + ROUNDC) >>> LSB);
      end
    end
  end

  task automatic finishUp();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      check(0, "watchdog", 0, 1);
      finishUp();
    end
  end

  initial begin
    logic [TAPS*16-1:0] v;
    longint held;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R7 outValid in reset", longint'(outValid), 0);
    check(outSum == '0, "R7 outSum in reset", outVal(), 0);
    rstN = 1'b1;

    // R3 all zero
    send('0);
    idle();
    check(outValid == 1'b1, "R5 latency", longint'(outValid), 1);
    check(outSum == '0, "R3 zero in zero out", outVal(), 0);

    // R4 most negative everywhere
    v = {TAPS{16'h8000}};
    send(v);
    idle();
    check(outVal() == ((exactOf(v) + ROUNDC) >>> LSB), "R4 most negative",
          outVal(), (exactOf(v) + ROUNDC) >>> LSB);
    held = outVal();

    // R6 idle with different samples on the bus
    sampleVec = {TAPS{16'h7FFF}};
    @(negedge clk);
    check(outValid == 1'b0, "R6 valid low when idle", longint'(outValid), 0);
    check(outVal() == held, "R6 output held", outVal(), held);
    sampleVec = {TAPS{16'h1234}};
    @(negedge clk);
    check(outVal() == held, "R6 output still held", outVal(), held);

    // R9 tap ordering with a single nonzero tap
    for (int t = 0; t < TAPS; t++) begin
      v = '0;
      v[t*16 +: 16] = 16'd32;
      send(v);
      idle();
      check(outVal() == ((32 * coefTab[t] + ROUNDC) >>> LSB), "R9 tap order",
            outVal(), (32 * coefTab[t] + ROUNDC) >>> LSB);
    end

    // corner sets: all ones, max positive, mixed extremes (R1/R4)
    send({TAPS{16'hFFFF}});
    send({TAPS{16'h7FFF}});
    send({16'h8000, 16'h7FFF, 16'h8000, 16'h7FFF});
    send({16'h7FFF, 16'h8000, 16'hFFFF, 16'h0001});
    idle();

    // R8 back-to-back random sets, half with low columns clear
    for (int n = 0; n < 3000; n++) begin
      v = {$urandom(), $urandom()};
      if (n % 2 == 0)
        for (int t = 0; t < TAPS; t++) v[t*16 +: DROP] = '0;
      send(v);
    end
    idle();
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R8 all results delivered", longint'(sb.size()), 0);
    check(popped == pushed, "R8 result count", longint'(popped), longint'(pushed));

    done = 1;
    finishUp();
  end
endmodule